// File: doc/BRIEF.md
# Regulator Start-up and Voltage-Code Sequencer

This block is the digital sequencer in front of a two-rail voltage regulator. It waits for the supply to leave power-on reset. When the enable input is registered high, it latches a two-bit boot code from a pair of strap pins. It then waits a fixed programming delay. During that delay it keeps capturing the slew-rate select. After the delay it walks the DAC code up from zero, one LSB per step interval, until the code equals the boot voltage. At that point it raises power-good for both rails.

After power-good, and while the system power-ok input is high, the block takes new voltage codes from a simple command port. It ramps to each new code at the slew rate captured during the delay. When the DAC code arrives at a target that was above it, the block gives a one-cycle completion pulse. Dropping enable, or losing the power-on-reset indication, returns the block to idle at once.

Top module: `vr_boot_seq`

## Requirements
- R1: While `por_ok_i` is low, the enable input has no effect: `dac_code_o` stays 0, and `pgood_o` and `otf_done_o` stay 0.
- R2: At the clock edge that first registers `en_i` high with `por_ok_i` high (the start edge), the boot target is taken from `strap_i`. Code 0 gives 24, 1 gives 48, 2 gives 72 and 3 gives 96. Strap changes after the start edge are ignored.
- R3: `dac_code_o` stays 0 for `DELAY_CYC` cycles after the start edge. It first becomes 1 after edge start+`DELAY_CYC`+L, where L is the step interval.
- R4: `slew_sel_i` is captured at every edge during the delay. The step interval L is `STEP_BASE << sel` cycles for sel 0 to 3. Changes after the delay has ended are ignored.
- R5: The DAC code never jumps. It moves by one LSB per step interval until it equals its target, and then holds.
- R6: `pgood_o` rises exactly one cycle after `dac_code_o` first equals the boot target.
- R7: A command (`cmd_valid_i` high at an edge) is ignored unless `pgood_o` and `pwr_ok_i` are both high in that cycle.
- R8: An accepted command above the present code restarts the step timer at the accept edge, so the first step lands L cycles later. The code then ramps up, and `otf_done_o` is high for exactly the one cycle in which `dac_code_o` first shows the target.
- R9: An accepted command below the present code ramps the code down one LSB per interval, and `otf_done_o` stays low.
- R10: One edge after `en_i` falls, `dac_code_o` is 0 and both `pgood_o` and `otf_done_o` are 0. A later rise of `en_i` starts the whole sequence again.
- R11: A command accepted at the same edge where the code lands on an earlier, higher target still produces the pulse for that earlier target. The new target then takes over, with its step timing counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Supply power-on-reset indication valid |
| en_i | input | 1 | Regulator enable |
| pwr_ok_i | input | 1 | System power-ok |
| strap_i | input | 2 | Boot voltage code pins |
| slew_sel_i | input | 2 | Step interval select |
| cmd_valid_i | input | 1 | New voltage command strobe |
| cmd_code_i | input | DAC_W | Commanded DAC code |
| dac_code_o | output | DAC_W | DAC code to the analog loop |
| pgood_o | output | 1 | Power-good for both rails |
| otf_done_o | output | 1 | One-cycle pulse when an upward change completes |

## Verification
Two events can fall in the same cycle: acceptance of a new command, and the step on which the DAC lands on the previous target. The bench first issues an upward command. It then places a second, higher command exactly on the predicted landing edge. After that edge it expects the completion pulse for the first target together with the first target's code. It then expects the second target to be reached one full step interval later, which shows that the step timer restarted on acceptance.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SOFT = 2'd2,
    ST_RUN  = 2'd3
  } seq_st_e;

  // Cycles between DAC steps for a slew select value.
  function automatic int unsigned step_len(input int unsigned base,
                                           input logic [1:0] sel);
    return base << sel;
  endfunction

  // Boot voltage for a strap code, taken from a packed table of 4 entries.
  function automatic logic [15:0] boot_pick(input logic [63:0] tbl,
                                            input int unsigned w,
                                            input logic [1:0] code);
    logic [15:0] v;
    v = 16'((tbl >> (int'(code) * w)) & ((64'd1 << w) - 64'd1));
    return v;
  endfunction

endpackage

// File: rtl/vr_step_timer.sv
module vr_step_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] last,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || (cnt == last)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vr_dac_ramp.sv
module vr_dac_ramp #(
  parameter int unsigned DAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             boot_ld,
  input  logic [DAC_W-1:0] boot_code,
  input  logic             cmd_ld,
  input  logic [DAC_W-1:0] cmd_code,
  input  logic             tick,
  output logic [DAC_W-1:0] dac_o,
  output logic             at_tgt_o,
  output logic             land_o,
  output logic             otf_o
);
  logic [DAC_W-1:0] tgt;
  logic [DAC_W-1:0] dac_nxt;
  logic             rise_pend;
  logic             moving;

  function automatic logic [DAC_W-1:0] one_step(input logic [DAC_W-1:0] cur,
                                                input logic [DAC_W-1:0] goal);
    if (goal > cur) return cur + 1'b1;
    if (goal < cur) return cur - 1'b1;
    return cur;
  endfunction

  assign at_tgt_o = (dac_o == tgt);
  assign moving   = tick && !at_tgt_o;
  assign dac_nxt  = moving ? one_step(dac_o, tgt) : dac_o;
  assign land_o   = moving && rise_pend && (dac_nxt == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_o     <= '0;
      tgt       <= '0;
      rise_pend <= 1'b0;
      otf_o     <= 1'b0;
    end else if (clr) begin
      dac_o     <= '0;
      tgt       <= '0;
      rise_pend <= 1'b0;
      otf_o     <= 1'b0;
    end else begin
      dac_o <= dac_nxt;
      otf_o <= land_o;
      if (boot_ld) begin
        tgt       <= boot_code;
        rise_pend <= 1'b0;
      end else if (cmd_ld) begin
        tgt       <= cmd_code;
        rise_pend <= (cmd_code > dac_nxt);
      end else if (land_o) begin
        rise_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vr_boot_seq.sv
module vr_boot_seq
  import vr_seq_pkg::*;
#(
  parameter int unsigned     DAC_W     = 8,
  parameter int unsigned     DELAY_CYC = 800000,
  parameter int unsigned     STEP_BASE = 4,
  parameter logic [4*8-1:0]  BOOT_TBL  = {8'd96, 8'd72, 8'd48, 8'd24}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok_i,
  input  logic             en_i,
  input  logic             pwr_ok_i,
  input  logic [1:0]       strap_i,
  input  logic [1:0]       slew_sel_i,
  input  logic             cmd_valid_i,
  input  logic [DAC_W-1:0] cmd_code_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             pgood_o,
  output logic             otf_done_o
);
  localparam int unsigned MAX_LEN = STEP_BASE * 8;
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);
  localparam int unsigned DLY_W   = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);

  seq_st_e          state;
  logic [DLY_W-1:0] dly_cnt;
  logic [1:0]       slew_q;
  logic             active;

  // Named internal events, observed by the bound checker.
  logic             boot_ld;
  logic             cmd_acc;
  logic             step_tick;
  logic             step_run;
  logic             at_tgt;
  logic             land;
  logic [CNT_W-1:0] step_last;
  logic [DAC_W-1:0] boot_code;

  assign active    = por_ok_i && en_i;
  assign boot_ld   = active && (state == ST_IDLE);
  assign step_run  = active && ((state == ST_SOFT) || (state == ST_RUN));
  assign cmd_acc   = active && (state == ST_RUN) && pwr_ok_i && cmd_valid_i;
  assign step_last = CNT_W'(step_len(STEP_BASE, slew_q) - 1);
  assign boot_code = DAC_W'(boot_pick(64'(BOOT_TBL), 8, strap_i));
  assign pgood_o   = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dly_cnt <= '0;
      slew_q  <= '0;
    end else if (!active) begin
      state   <= ST_IDLE;
      dly_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state   <= ST_WAIT;
          dly_cnt <= '0;
        end
        ST_WAIT: begin
          slew_q <= slew_sel_i;
          if (dly_cnt == DLY_W'(DELAY_CYC - 1)) state <= ST_SOFT;
          else dly_cnt <= dly_cnt + 1'b1;
        end
        ST_SOFT: if (at_tgt) state <= ST_RUN;
        ST_RUN:  state <= ST_RUN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  vr_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (step_run),
    .restart (cmd_acc),
    .last    (step_last),
    .tick    (step_tick)
  );

  vr_dac_ramp #(.DAC_W(DAC_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!active),
    .boot_ld   (boot_ld),
    .boot_code (boot_code),
    .cmd_ld    (cmd_acc),
    .cmd_code  (cmd_code_i),
    .tick      (step_tick),
    .dac_o     (dac_code_o),
    .at_tgt_o  (at_tgt),
    .land_o    (land),
    .otf_o     (otf_done_o)
  );
endmodule

// File: rtl/vr_boot_seq_chk.sv
module vr_boot_seq_chk #(
  parameter int unsigned DAC_W     = 8,
  parameter int unsigned DELAY_CYC = 800000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_ok_i,
  input logic             en_i,
  input logic             pwr_ok_i,
  input logic [DAC_W-1:0] dac_code_o,
  input logic             pgood_o,
  input logic             otf_done_o,
  input logic             cmd_acc
);
  localparam int unsigned SAT  = DELAY_CYC + 2;
  localparam int unsigned DC_W = $clog2(SAT + 1) + 1;

  logic [DC_W-1:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_cnt <= '0;
    else if (!(en_i && por_ok_i)) on_cnt <= '0;
    else if (on_cnt != DC_W'(SAT)) on_cnt <= on_cnt + 1'b1;
  end

  // R10
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && por_ok_i) |=> (dac_code_o == '0) && !pgood_o && !otf_done_o);

  // R5
  one_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && por_ok_i) |=> (dac_code_o == $past(dac_code_o)) ||
                           (dac_code_o == $past(dac_code_o) + 1'b1) ||
                           (dac_code_o == $past(dac_code_o) - 1'b1));

  // R3
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_cnt <= DC_W'(DELAY_CYC)) |-> (dac_code_o == '0));

  // R8
  otf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otf_done_o |-> pgood_o && (dac_code_o == $past(dac_code_o) + 1'b1));

  // R7
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |-> pgood_o && pwr_ok_i);

  // R6
  pg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $stable(dac_code_o));
endmodule

bind vr_boot_seq vr_boot_seq_chk #(.DAC_W(DAC_W), .DELAY_CYC(DELAY_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_ok_i   (por_ok_i),
  .en_i       (en_i),
  .pwr_ok_i   (pwr_ok_i),
  .dac_code_o (dac_code_o),
  .pgood_o    (pgood_o),
  .otf_done_o (otf_done_o),
  .cmd_acc    (cmd_acc)
);

// File: tb/test_vr_boot_seq.sv
`timescale 1ns/1ps
module test_vr_boot_seq;
  localparam int DLY  = 20;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_ok = 1'b0;
  logic       en = 1'b0;
  logic       pwr_ok = 1'b0;
  logic [1:0] strap = 2'd0;
  logic [1:0] slew = 2'd0;
  logic       cmd_v = 1'b0;
  logic [7:0] cmd_c = 8'd0;
  logic [7:0] dac;
  logic       pg;
  logic       otf;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vr_boot_seq #(.DAC_W(8), .DELAY_CYC(DLY), .STEP_BASE(BASE)) i_vr_boot_seq (
    .clk(clk), .rst_n(rst_n), .por_ok_i(por_ok), .en_i(en), .pwr_ok_i(pwr_ok),
    .strap_i(strap), .slew_sel_i(slew), .cmd_valid_i(cmd_v), .cmd_code_i(cmd_c),
    .dac_code_o(dac), .pgood_o(pg), .otf_done_o(otf)
  );

  function automatic int boot_of(input int s);
    return 24 * (s + 1);
  endfunction

  function automatic int len_of(input int sel);
    return BASE * (1 << sel);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input int code);
    cmd_v = 1'b1;
    cmd_c = 8'(code);
    cyc(1);
    cmd_v = 1'b0;
  endtask

  task automatic t_reset();
    chk(dac == 0 && !pg && !otf, "R1 reset", dac, 0);
    rst_n = 1'b1;
    en = 1'b1;
    cyc(DLY + 40);
    chk(dac == 0, "R1 no por dac", dac, 0);
    chk(!pg && !otf, "R1 no por flags", pg, 0);
    en = 1'b0;
    por_ok = 1'b1;
    cyc(2);
  endtask

  // Boot sequence; leaves the block regulating at the boot voltage.
  task automatic t_boot(input int s, input int sel);
    int t, l;
    t = boot_of(s);
    l = len_of(sel);
    en = 1'b0;
    cyc(2);
    strap = 2'(s);
    slew = 2'(sel);
    en = 1'b1;
    cyc(1);
    chk(dac == 0, "R3 after start", dac, 0);
    strap = 2'(s + 1);          // R2: ignored after the start edge
    pwr_ok = 1'b1;
    send_cmd(200);              // R7: ignored before power-good
    cyc(DLY - 1);
    chk(dac == 0, "R3 end of delay", dac, 0);
    slew = 2'(sel + 1);         // R4: ignored after the delay
    cyc(l - 1);
    chk(dac == 0, "R4 before first step", dac, 0);
    cyc(1);
    chk(dac == 1, "R3 first step", dac, 1);
    cyc(l);
    chk(dac == 2, "R5 second step", dac, 2);
    cyc((t - 2) * l);
    chk(dac == t, "R2 boot target", dac, t);
    chk(!pg, "R6 pgood not early", pg, 0);
    cyc(1);
    chk(pg, "R6 pgood rises", pg, 1);
    chk(dac == t, "R7 early command ignored", dac, t);
  endtask

  task automatic t_gate(input int sel);
    int cur;
    cur = dac;
    pwr_ok = 1'b0;
    cyc(1);
    send_cmd(cur + 5);
    cyc(len_of(sel) * 8);
    chk(dac == cur, "R7 no power-ok", dac, cur);
    pwr_ok = 1'b1;
  endtask

  task automatic t_up(input int d, input int sel);
    int cur, l;
    cur = dac;
    l = len_of(sel);
    send_cmd(cur + d);
    cyc(d * l - 1);
    chk(dac == cur + d - 1 && !otf, "R8 before landing", dac, cur + d - 1);
    cyc(1);
    chk(dac == cur + d, "R8 landed", dac, cur + d);
    chk(otf, "R8 pulse", otf, 1);
    cyc(1);
    chk(!otf, "R8 pulse one cycle", otf, 0);
  endtask

  task automatic t_down(input int d, input int sel);
    int cur, l, seen;
    cur = dac;
    l = len_of(sel);
    seen = 0;
    send_cmd(cur - d);
    for (int i = 0; i < d * l + 4; i++) begin
      if (otf) seen++;
      cyc(1);
    end
    chk(dac == cur - d, "R9 down target", dac, cur - d);
    chk(seen == 0, "R9 no pulse", seen, 0);
  endtask

  task automatic t_same(input int sel);
    int cur, l;
    cur = dac;
    l = len_of(sel);
    send_cmd(cur + 2);
    cyc(2 * l - 1);
    chk(dac == cur + 1, "R11 midway", dac, cur + 1);
    cmd_v = 1'b1;
    cmd_c = 8'(cur + 3);
    cyc(1);
    cmd_v = 1'b0;
    chk(dac == cur + 2 && otf, "R11 landing pulse", {dac, 7'd0, otf}, {8'(cur + 2), 8'd1});
    cyc(l - 1);
    chk(dac == cur + 2 && !otf, "R11 timer restarted", dac, cur + 2);
    cyc(1);
    chk(dac == cur + 3 && otf, "R11 second landing", dac, cur + 3);
  endtask

  task automatic t_drop();
    send_cmd(dac + 10);
    cyc(3);
    en = 1'b0;
    cyc(1);
    chk(dac == 0 && !pg && !otf, "R10 disable clears", dac, 0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    t_boot(0, 0);
    t_gate(0);
    t_up(3, 0);
    t_down(2, 0);
    t_same(0);
    t_drop();
    t_boot(3, 1);
    t_up(4, 1);
    t_drop();
    t_boot(1, 3);
    t_same(3);
    t_down(3, 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule